// File: doc/BRIEF.md
# Status Register Field-Masked Write Unit

This block keeps the current processor status word together with one saved status word for each privileged mode that owns one. A single operation strobe carries a command: read a status word into the general-register result, write a status word under a four-lane byte mask, or restore the current word from the saved word of the active mode. The write source is either a general register value or an 8-bit immediate rotated right by twice a 4-bit rotate field.

The active mode is taken from bits [4:0] of the current word, and it picks which saved word a saved-side access reaches. Illegal requests are refused with no state change, and a one-cycle error pulse is raised. Illegal requests are a saved-side access from a mode without a saved word, a mode encoding that is not recognised, a read with non-canonical opcode padding, and a current-word write that would flip the state bit.

Top module: `stat_reg_unit`

## Requirements
- R1: After reset the current word is 0x000000D3 (supervisor mode, both interrupt masks set), every saved word is zero, and rd_data and err are zero.
- R2: A read (op_kind 2'b00) with pad_lo == 0 and pad_hi == 4'hF loads rd_data, one cycle after the strobe, with the current word when sel_saved is 0 or with the active mode's saved word when sel_saved is 1.
- R3: A read with pad_lo != 0 or pad_hi != 4'hF raises err and leaves rd_data unchanged.
- R4: A write (op_kind 2'b01) replaces byte lane k of the target word only where fld_mask[k] is 1: lane 0 is bits [7:0] (control), lane 1 bits [15:8] (extension), lane 2 bits [23:16] (status), lane 3 bits [31:24] (flags); unmasked lanes keep their value. The flags lane is written whole, including the unallocated bits [26:24] and the saturation bit 27.
- R5: With use_imm set, the write source is the zero-extended imm8 rotated right by 2*imm_rot bits (0 to 30); with use_imm clear it is reg_val.
- R6: sel_saved = 1 targets the saved word of the active mode only; the saved words of other modes are untouched.
- R7: In user mode (5'b10000) or system mode (5'b11111), any saved-side read or write, or a restore, raises err and changes no state.
- R8: A write to the current word whose result differs from the old word in bit 5 (state bit) raises err and changes no state.
- R9: A restore (op_kind 2'b10) copies the active mode's saved word into the current word, visible one cycle after the strobe.
- R10: When the current mode field is none of 10000, 10001, 10010, 10011, 10111, 11011, 11111, every read, write or restore raises err and changes no state.
- R11: err is registered: it is high for exactly the one cycle after a refused operation and low otherwise; op_kind 2'b11 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation strobe, one cycle per operation |
| op_kind | input | 2 | 00 read, 01 write, 10 restore, 11 none |
| sel_saved | input | 1 | 0 current word, 1 saved word of active mode |
| fld_mask | input | 4 | Byte-lane write enables, lane 0 = bits [7:0] |
| use_imm | input | 1 | Select rotated immediate as write source |
| imm8 | input | 8 | Immediate byte |
| imm_rot | input | 4 | Rotate-right amount divided by two |
| reg_val | input | 32 | Register write source |
| pad_lo | input | 12 | Read opcode padding, must be zero |
| pad_hi | input | 4 | Read opcode padding, must be all ones |
| cur_word | output | 32 | Current status word |
| rd_data | output | 32 | Result of the last accepted read |
| err | output | 1 | One-cycle refusal pulse |

## Verification
A corrupted current word shows on cur_word the cycle after the faulty update, and a wrong mode field also shows one operation later, because saved-side access, restore and refusal all depend on it. A wrong saved word or bank index is invisible until a saved-side read or restore in that mode, so the bench writes distinct values to two banks, switches modes and reads each back. Lane-mask, rotate and state-bit faults are caught by comparing cur_word or rd_data against values worked out by hand the cycle after each write.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned LANES  = WORD_W / LANE_W;
  localparam int unsigned T_BIT  = 5;

  typedef enum logic [1:0] {
    OP_READ    = 2'b00,
    OP_WRITE   = 2'b01,
    OP_RESTORE = 2'b10,
    OP_NONE    = 2'b11
  } op_e;

  localparam logic [4:0] M_USR = 5'b10000;
  localparam logic [4:0] M_FIQ = 5'b10001;
  localparam logic [4:0] M_IRQ = 5'b10010;
  localparam logic [4:0] M_SVC = 5'b10011;
  localparam logic [4:0] M_ABT = 5'b10111;
  localparam logic [4:0] M_UND = 5'b11011;
  localparam logic [4:0] M_SYS = 5'b11111;

  localparam logic [WORD_W-1:0] RESET_WORD = {{(WORD_W-8){1'b0}}, 8'hC0} | {{(WORD_W-5){1'b0}}, M_SVC};

  // Bank slot of a mode; 7 means the mode owns no saved word.
  function automatic logic [2:0] bank_of(input logic [4:0] m);
    case (m)
      M_FIQ:   bank_of = 3'd0;
      M_IRQ:   bank_of = 3'd1;
      M_SVC:   bank_of = 3'd2;
      M_ABT:   bank_of = 3'd3;
      M_UND:   bank_of = 3'd4;
      default: bank_of = 3'd7;
    endcase
  endfunction

  function automatic logic mode_known(input logic [4:0] m);
    mode_known = (m == M_USR) || (m == M_SYS) || (bank_of(m) != 3'd7);
  endfunction

  // Rotate zero-extended byte right by 2*r.
  function automatic logic [WORD_W-1:0] rot_imm(input logic [7:0] b, input logic [3:0] r);
    logic [2*WORD_W-1:0] dbl;
    logic [WORD_W-1:0]   x;
    x   = {{(WORD_W-8){1'b0}}, b};
    dbl = {x, x} >> {r, 1'b0};
    rot_imm = dbl[WORD_W-1:0];
  endfunction
endpackage

// File: rtl/stat_operand.sv
module stat_operand
  import stat_pkg::*;
(
  input  logic              use_imm,
  input  logic [7:0]        imm8,
  input  logic [3:0]        imm_rot,
  input  logic [WORD_W-1:0] reg_val,
  output logic [WORD_W-1:0] src
);
  logic [WORD_W-1:0] imm_word;

  assign imm_word = rot_imm(imm8, imm_rot);
  assign src      = use_imm ? imm_word : reg_val;

  // R5: rotation keeps exactly the bits of the byte
  always_comb begin
    assert_rot_popcount_R5: assert ($countones(imm_word) == $countones(imm8));
  end
endmodule

// File: rtl/stat_lane_merge.sv
module stat_lane_merge
  import stat_pkg::*;
(
  input  logic [WORD_W-1:0] old_word,
  input  logic [WORD_W-1:0] new_word,
  input  logic [LANES-1:0]  mask,
  output logic [WORD_W-1:0] merged
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign merged[k*LANE_W +: LANE_W] = mask[k] ? new_word[k*LANE_W +: LANE_W]
                                                : old_word[k*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/stat_saved_bank.sv
module stat_saved_bank
  import stat_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 5,
  localparam int unsigned IDX_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] slot [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             slot[b] <= '0;
      else if (wr_en && idx == IDX_W'(b))     slot[b] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (idx == IDX_W'(b)) rd_data = slot[b];
  end
endmodule

// File: rtl/stat_reg_unit.sv
module stat_reg_unit
  import stat_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [1:0]        op_kind,
  input  logic              sel_saved,
  input  logic [3:0]        fld_mask,
  input  logic              use_imm,
  input  logic [7:0]        imm8,
  input  logic [3:0]        imm_rot,
  input  logic [31:0]       reg_val,
  input  logic [11:0]       pad_lo,
  input  logic [3:0]        pad_hi,
  output logic [31:0]       cur_word,
  output logic [31:0]       rd_data,
  output logic              err
);
  op_e               kind;
  logic [WORD_W-1:0] cur_q, rd_q, src, saved_cur, target_old, merged;
  logic              err_q;
  logic [4:0]        mode;
  logic [2:0]        bidx;
  logic              known, has_saved, needs_saved, pad_bad, t_flip, viol;
  logic              do_read, do_write, do_restore, live;

  assign kind      = op_e'(op_kind);
  assign mode      = cur_q[4:0];
  assign bidx      = bank_of(mode);
  assign known     = mode_known(mode);
  assign has_saved = (bidx != 3'd7);

  stat_operand u_operand (
    .use_imm (use_imm), .imm8 (imm8), .imm_rot (imm_rot),
    .reg_val (reg_val), .src (src)
  );

  stat_saved_bank #(.NUM_BANKS(NUM_BANKS)) u_bank (
    .clk (clk), .rst_n (rst_n), .wr_en (do_write && sel_saved),
    .idx (bidx), .wr_data (merged), .rd_data (saved_cur)
  );

  assign target_old = sel_saved ? saved_cur : cur_q;

  stat_lane_merge u_merge (
    .old_word (target_old), .new_word (src), .mask (fld_mask), .merged (merged)
  );

  // Internal events brought out as named wires
  assign live        = op_valid && (kind != OP_NONE);
  assign needs_saved = ((kind == OP_READ || kind == OP_WRITE) && sel_saved) || (kind == OP_RESTORE);
  assign pad_bad     = (pad_lo != '0) || (pad_hi != 4'hF);
  assign t_flip      = !sel_saved && (merged[T_BIT] != cur_q[T_BIT]);
  assign viol        = live && (!known || (needs_saved && !has_saved) ||
                                (kind == OP_READ && pad_bad) || (kind == OP_WRITE && t_flip));
  assign do_read     = live && !viol && kind == OP_READ;
  assign do_write    = live && !viol && kind == OP_WRITE;
  assign do_restore  = live && !viol && kind == OP_RESTORE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= RESET_WORD;
      rd_q  <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= viol;
      if (do_read)                    rd_q  <= target_old;
      if (do_write && !sel_saved)     cur_q <= merged;
      else if (do_restore)            cur_q <= saved_cur;
    end
  end

  assign cur_word = cur_q;
  assign rd_data  = rd_q;
  assign err      = err_q;

  assert_read_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    do_read |=> rd_q == $past(target_old));

  for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
    assert_lane_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (do_write && !sel_saved && !fld_mask[k]) |=>
        cur_q[k*LANE_W +: LANE_W] == $past(cur_q[k*LANE_W +: LANE_W]));
  end

  assert_saved_refused_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (live && needs_saved && (mode == M_USR || mode == M_SYS)) |=> err_q);

  assert_err_no_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> cur_q == $past(cur_q));

  assert_t_bit_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (do_write && !sel_saved) |=> cur_q[T_BIT] == $past(cur_q[T_BIT]));

  assert_restore_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    do_restore |=> cur_q == $past(saved_cur));

  assert_unknown_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !known) |=> err_q);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !live |=> !err_q && $stable(cur_q) && $stable(rd_q));
endmodule

// File: tb/test_stat_reg_unit.sv
module test_stat_reg_unit;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        op_valid = 1'b0, sel_saved = 1'b0, use_imm = 1'b0;
  logic [1:0]  op_kind = 2'b11;
  logic [3:0]  fld_mask = '0, imm_rot = '0, pad_hi = 4'hF;
  logic [7:0]  imm8 = '0;
  logic [31:0] reg_val = '0;
  logic [11:0] pad_lo = '0;
  logic [31:0] cur_word, rd_data;
  logic        err;
  int          checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  stat_reg_unit i_stat_reg_unit (
    .clk, .rst_n, .op_valid, .op_kind, .sel_saved, .fld_mask, .use_imm,
    .imm8, .imm_rot, .reg_val, .pad_lo, .pad_hi, .cur_word, .rd_data, .err
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] k, input logic s, input logic [3:0] m,
                       input logic ui, input logic [7:0] i8, input logic [3:0] r,
                       input logic [31:0] v, input logic [11:0] lo, input logic [3:0] hi);
    @(negedge clk);
    op_kind = k; sel_saved = s; fld_mask = m; use_imm = ui; imm8 = i8;
    imm_rot = r; reg_val = v; pad_lo = lo; pad_hi = hi; op_valid = 1'b1;
    @(posedge clk); #1;
    op_valid = 1'b0; op_kind = 2'b11;
  endtask

  task automatic wr_reg(input logic s, input logic [3:0] m, input logic [31:0] v);
    issue(2'b01, s, m, 1'b0, 8'h00, 4'h0, v, 12'h000, 4'hF);
  endtask
  task automatic wr_imm(input logic s, input logic [3:0] m, input logic [7:0] b, input logic [3:0] r);
    issue(2'b01, s, m, 1'b1, b, r, 32'hDEAD_BEEF, 12'h000, 4'hF);
  endtask
  task automatic rd(input logic s);
    issue(2'b00, s, 4'h0, 1'b0, 8'h00, 4'h0, 32'h0, 12'h000, 4'hF);
  endtask
  task automatic restore();
    issue(2'b10, 1'b1, 4'h0, 1'b0, 8'h00, 4'h0, 32'h0, 12'h000, 4'hF);
  endtask
  task automatic idle_err_low(input string req);
    @(negedge clk); @(posedge clk); #1;
    chk(req, {31'b0, err}, 32'h0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; repeat (2) @(posedge clk); #1;
    chk("R1 cur", cur_word, 32'h0000_00D3);
    chk("R1 rd", rd_data, 32'h0);
    chk("R1 err", {31'b0, err}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    rd(1'b1);
    chk("R1 saved zero", rd_data, 32'h0);
  endtask

  task automatic t_saved_write_read();
    wr_reg(1'b1, 4'hF, 32'hA000_001F);
    chk("R6 cur untouched", cur_word, 32'h0000_00D3);
    rd(1'b1);
    chk("R2 saved read", rd_data, 32'hA000_001F);
    rd(1'b0);
    chk("R2 cur read", rd_data, 32'h0000_00D3);
  endtask

  task automatic t_flags_imm();
    wr_reg(1'b0, 4'b1000, 32'h0800_0000);
    chk("R4 saturation set", cur_word, 32'h0800_00D3);
    wr_imm(1'b0, 4'b1000, 8'hF0, 4'd4);
    chk("R5 R4 flags imm clears sat", cur_word, 32'hF000_00D3);
  endtask

  task automatic t_lanes();
    wr_reg(1'b0, 4'b0110, 32'hFFFF_FFFF);
    chk("R4 middle lanes", cur_word, 32'hF0FF_FFD3);
    wr_reg(1'b0, 4'b0110, 32'h0);
    chk("R4 middle lanes clear", cur_word, 32'hF000_00D3);
  endtask

  task automatic t_rotate_saved();
    wr_imm(1'b1, 4'hF, 8'h81, 4'd1);
    rd(1'b1);
    chk("R5 ror2 wrap", rd_data, 32'h4000_0020);
    wr_imm(1'b1, 4'b0001, 8'h5A, 4'd0);
    rd(1'b1);
    chk("R5 rot0 control", rd_data, 32'h4000_005A);
    wr_reg(1'b1, 4'hF, 32'hA000_001F);
  endtask

  task automatic t_bad_pad();
    rd(1'b0);
    issue(2'b00, 1'b0, 4'h0, 1'b0, 8'h0, 4'h0, 32'h0, 12'h001, 4'hF);
    chk("R3 pad_lo err", {31'b0, err}, 32'h1);
    chk("R3 rd kept", rd_data, 32'hF000_00D3);
    issue(2'b00, 1'b1, 4'h0, 1'b0, 8'h0, 4'h0, 32'h0, 12'h000, 4'hE);
    chk("R3 pad_hi err", {31'b0, err}, 32'h1);
    chk("R3 rd kept 2", rd_data, 32'hF000_00D3);
    idle_err_low("R11 pulse ends");
  endtask

  task automatic t_state_bit();
    wr_reg(1'b0, 4'b0001, 32'h0000_00F3);
    chk("R8 err", {31'b0, err}, 32'h1);
    chk("R8 cur kept", cur_word, 32'hF000_00D3);
  endtask

  task automatic t_banks();
    wr_reg(1'b0, 4'b0001, 32'h0000_00D2);
    chk("R4 to irq", cur_word, 32'hF000_00D2);
    wr_reg(1'b1, 4'hF, 32'h1111_1111);
    rd(1'b1);
    chk("R6 irq bank", rd_data, 32'h1111_1111);
    wr_reg(1'b0, 4'b0001, 32'h0000_00D3);
    rd(1'b1);
    chk("R6 svc bank intact", rd_data, 32'hA000_001F);
  endtask

  task automatic t_restore_and_sys();
    restore();
    chk("R9 restore", cur_word, 32'hA000_001F);
    rd(1'b1);
    chk("R7 sys saved read err", {31'b0, err}, 32'h1);
    chk("R7 rd kept", rd_data, 32'hA000_001F);
    wr_reg(1'b1, 4'hF, 32'h0);
    chk("R7 sys saved write err", {31'b0, err}, 32'h1);
    restore();
    chk("R7 R9 sys restore err", {31'b0, err}, 32'h1);
    chk("R7 cur kept", cur_word, 32'hA000_001F);
    wr_reg(1'b0, 4'b0001, 32'h0000_0010);
    chk("R7 to user", cur_word, 32'hA000_0010);
    rd(1'b1);
    chk("R7 user saved read err", {31'b0, err}, 32'h1);
    issue(2'b11, 1'b0, 4'hF, 1'b0, 8'h0, 4'h0, 32'hFFFF_FFFF, 12'h0, 4'hF);
    chk("R11 none op", cur_word, 32'hA000_0010);
    chk("R11 none op err", {31'b0, err}, 32'h0);
  endtask

  task automatic t_bad_mode();
    wr_reg(1'b0, 4'b0001, 32'h0);
    chk("R10 mode zero", cur_word, 32'hA000_0000);
    rd(1'b0);
    chk("R10 read err", {31'b0, err}, 32'h1);
    wr_reg(1'b0, 4'b0001, 32'h0000_0013);
    chk("R10 write err", {31'b0, err}, 32'h1);
    chk("R10 cur kept", cur_word, 32'hA000_0000);
  endtask

  initial begin
    t_reset();
    t_saved_write_read();
    t_flags_imm();
    t_lanes();
    t_rotate_saved();
    t_bad_pad();
    t_state_bit();
    t_banks();
    t_restore_and_sys();
    t_bad_mode();
    @(negedge clk);
    t_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule